// File: doc/BRIEF.md
# Double-Buffered PWM Generator

A single pulse-width-modulation channel. A free-running counter counts from zero up to a programmed period value and then wraps. The output is high while the count is below the active duty value. Software programs the channel through a one-cycle register write port. The period, duty and control fields all sit behind this port, along with a write-to-clear command for the interrupt flag.

A new duty value is double-buffered. Software writes it into a staging register. It is copied into the active duty register only when the counter matches the period, so a cycle that has already started always finishes with the duty it started with. The period can be changed only while the channel is stopped. The channel raises a sticky flag on every period match. The flag is masked by an interrupt enable to form the request line. A select bit decides whether the pin is driven at all.

The channel is run by a two-state machine. `ST_OFF` is the stopped state: the counter is held at zero, the output is low, period writes are accepted and the active duty follows the staging register. `ST_RUN` is the counting state. The transition *arm* (`ST_OFF` to `ST_RUN`) fires on a control write with the enable bit set. The transition *halt* (`ST_RUN` to `ST_OFF`) fires on a control write with the enable bit clear. A control write that keeps the enable bit unchanged leaves the state as it is.

Top module: `pwm_dbuf`

## Requirements
- R1: A write (`wr_en` high for one cycle) to address 0 loads the period, to address 1 loads the duty staging register, and to address 2 loads the control fields: bit 0 enable, bit 1 output select, bit 2 interrupt enable. A write to address 3 with bit 0 set clears the flag.
- R2: While running, the count starts at 0 in the cycle after the arming write, steps by one per clock up to the period value P, and returns to 0 on the next clock. The output is high while the count is below the active duty, giving a repeat length of P+1 cycles.
- R3: An active duty of 0 gives a constantly low output. An active duty at or above the period gives a constantly high output.
- R4: A duty written while running leaves the current cycle unchanged and takes effect at the first count of 0 after the next period match.
- R5: In `ST_OFF` the counter is held at 0 and the output is low. Re-arming restarts the waveform from count 0.
- R6: In `ST_OFF` the active duty is loaded from the staging register every clock, so a duty written before arming applies from the first cycle.
- R7: A period write while in `ST_RUN` is ignored.
- R8: The flag is set on the clock after a period match and stays set until a clear write. A match and a clear in the same cycle leave it set.
- R9: `irq` is high exactly when the flag is set and the interrupt enable bit is 1.
- R10: `pwm_oe` equals the output select bit, and `pwm_pin` is the waveform gated by that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 period, 1 duty, 2 control, 3 flag clear) |
| wr_data | input | CNT_W | Write data |
| pwm_pin | output | 1 | Waveform gated by output select |
| pwm_oe | output | 1 | Pin drive enable |
| irq_flag | output | 1 | Sticky period-match flag |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
A wrong count or a lost wrap shows at `pwm_pin` within one period as a high phase of the wrong length, or as a repeat length other than P+1. A duty copied too early or too late into the active register makes the cycle in progress change shape, which is visible on the very cycle after the write. A corrupted state register shows at once as a waveform that keeps running after a halt, or a pin that stays low after arming. A flag that is set or cleared at the wrong time shows on `irq_flag` on the clock after the period match or the clear write.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    typedef enum logic [1:0] {
        ADDR_PERIOD = 2'd0,
        ADDR_DUTY   = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_CLEAR  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SEL_BIT = 1;
    localparam int CTRL_IE_BIT  = 2;
    localparam int CLEAR_BIT    = 0;

endpackage

// File: rtl/pwm_dbuf_fsm.sv
module pwm_dbuf_fsm
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_addr_e        wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             run,
    output logic             per_wr_ok
);

    run_state_e state_q, state_d;
    logic       ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (ctrl_wr && wr_data[CTRL_EN_BIT])  state_d = ST_RUN; // arm
            ST_RUN: if (ctrl_wr && !wr_data[CTRL_EN_BIT]) state_d = ST_OFF; // halt
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        run       = 1'b0;
        per_wr_ok = 1'b0;
        unique case (state_q)
            ST_OFF:  per_wr_ok = 1'b1;
            ST_RUN:  run       = 1'b1;
            default: per_wr_ok = 1'b0;
        endcase
    end

    // R5: a control write with enable clear always lands in ST_OFF
    p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_data[CTRL_EN_BIT]) |=> !run);

    // R1: a control write with enable set always lands in ST_RUN
    p_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[CTRL_EN_BIT]) |=> run);

endmodule

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_addr_e        wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             run,
    input  logic             per_wr_ok,
    input  logic             match,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] act_duty,
    output logic             out_sel,
    output logic             irq_en,
    output logic             flag
);

    logic [CNT_W-1:0] duty_stage;
    logic             per_wr, duty_wr, ctrl_wr, clr_wr;

    assign per_wr  = wr_en && (wr_addr == ADDR_PERIOD) && per_wr_ok;
    assign duty_wr = wr_en && (wr_addr == ADDR_DUTY);
    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign clr_wr  = wr_en && (wr_addr == ADDR_CLEAR) && wr_data[CLEAR_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period     <= '0;
            duty_stage <= '0;
            out_sel    <= 1'b0;
            irq_en     <= 1'b0;
        end else begin
            if (per_wr)  period     <= wr_data;
            if (duty_wr) duty_stage <= wr_data;
            if (ctrl_wr) begin
                out_sel <= wr_data[CTRL_SEL_BIT];
                irq_en  <= wr_data[CTRL_IE_BIT];
            end
        end
    end

    // shadow latch: transparent while stopped, period-boundary load while running
    always_ff @(posedge clk) begin
        if (!rst_n)              act_duty <= '0;
        else if (!run || match)  act_duty <= duty_stage;
    end

    // sticky flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (match)  flag <= 1'b1;
        else if (clr_wr) flag <= 1'b0;
    end

    p_period_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(period));

    p_duty_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !match) |=> $stable(act_duty));

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag);

endmodule

// File: rtl/pwm_dbuf_core.sv
module pwm_dbuf_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] act_duty,
    output logic             match,
    output logic             wave
);

    logic [CNT_W-1:0] cnt_q;
    logic             below, saturate;

    assign match = run && (cnt_q == period);

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (!run)  cnt_q <= '0;
        else if (match) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    assign below    = (cnt_q < act_duty);
    assign saturate = (act_duty >= period);
    assign wave     = run && (below || saturate);

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (cnt_q == '0));

    p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= period));

    p_held_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_pin,
    output logic             pwm_oe,
    output logic             irq_flag,
    output logic             irq
);

    reg_addr_e        addr;
    logic             run, per_wr_ok, match, wave, out_sel, irq_en, flag;
    logic [CNT_W-1:0] period, act_duty;

    assign addr = reg_addr_e'(wr_addr);

    pwm_dbuf_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (addr),
        .wr_data   (wr_data),
        .run       (run),
        .per_wr_ok (per_wr_ok)
    );

    pwm_dbuf_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (addr),
        .wr_data   (wr_data),
        .run       (run),
        .per_wr_ok (per_wr_ok),
        .match     (match),
        .period    (period),
        .act_duty  (act_duty),
        .out_sel   (out_sel),
        .irq_en    (irq_en),
        .flag      (flag)
    );

    pwm_dbuf_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .period   (period),
        .act_duty (act_duty),
        .match    (match),
        .wave     (wave)
    );

    assign pwm_oe   = out_sel;
    assign pwm_pin  = wave && out_sel;
    assign irq_flag = flag;
    assign irq      = flag && irq_en;

    p_low_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm_pin);

    p_pin_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_oe |-> !pwm_pin);

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_flag);

endmodule

// File: tb/pwm_dbuf_bench.sv
module pwm_dbuf_bench;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             pwm_pin, pwm_oe, irq_flag, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwm_dbuf #(.CNT_W(CNT_W)) u_pwm_dbuf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_pin(pwm_pin), .pwm_oe(pwm_oe),
        .irq_flag(irq_flag), .irq(irq)
    );

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
        end
    endtask

    // returns at the negedge right after the write is captured
    task automatic write(input logic [1:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        check(pwm_pin, 1'b0, "R5 reset pin");
        check(pwm_oe, 1'b0, "R10 reset oe");
        check(irq_flag, 1'b0, "R8 reset flag");
        check(irq, 1'b0, "R9 reset irq");
    endtask

    // period 4, duty 2; tracks a cycle index from the arming write
    task automatic t_run_and_double_buffer();
        write(2'd0, 8'd4);
        write(2'd1, 8'd2);
        write(2'd2, 8'b111);
        for (int i = 0; i < 10; i++) begin
            check(pwm_pin, (i % 5) < 2, "R2 waveform");
            check(pwm_oe, 1'b1, "R10 oe");
            if (i == 4) check(irq_flag, 1'b0, "R8 flag before match");
            if (i == 5) begin
                check(irq_flag, 1'b1, "R8 flag after match");
                check(irq, 1'b1, "R9 irq enabled");
            end
            @(negedge clk);
        end
        // index 10: period write while running must be ignored
        write(2'd0, 8'd1);
        for (int i = 12; i < 20; i++) begin
            check(pwm_pin, (i % 5) < 2, "R7 period write ignored");
            @(negedge clk);
        end
        // index 20: duty 4 (>= period) mid-cycle
        write(2'd1, 8'd4);
        for (int i = 22; i < 30; i++) begin
            check(pwm_pin, (i < 25) ? ((i % 5) < 2) : 1'b1, "R4/R3 duty full");
            @(negedge clk);
        end
        // index 30: duty 0
        write(2'd1, 8'd0);
        for (int i = 32; i < 40; i++) begin
            check(pwm_pin, (i < 35) ? 1'b1 : 1'b0, "R4/R3 duty zero");
            @(negedge clk);
        end
        // index 40
        check(irq_flag, 1'b1, "R8 flag sticky");
        write(2'd3, 8'd1);
        check(irq_flag, 1'b0, "R8 flag cleared");
        @(negedge clk); @(negedge clk); @(negedge clk);
        check(irq_flag, 1'b1, "R8 flag set again");
        @(negedge clk); @(negedge clk); @(negedge clk);
        // index 48: clear lands on the match edge at index 49
        write(2'd3, 8'd1);
        check(irq_flag, 1'b1, "R8 set wins over clear");
        write(2'd2, 8'b110);
        for (int i = 0; i < 3; i++) begin
            check(pwm_pin, 1'b0, "R5 low when stopped");
            @(negedge clk);
        end
    endtask

    task automatic t_stopped_loads();
        write(2'd3, 8'd1);
        check(irq_flag, 1'b0, "R8 clear while stopped");
        write(2'd0, 8'd2);
        write(2'd1, 8'd1);
        write(2'd2, 8'b011);
        for (int i = 0; i < 9; i++) begin
            check(pwm_pin, (i % 3) < 1, "R6 new period and duty");
            if (i == 3) begin
                check(irq_flag, 1'b1, "R8 flag period 2");
                check(irq, 1'b0, "R9 irq masked");
            end
            @(negedge clk);
        end
        @(negedge clk);
        write(2'd2, 8'b010);
        check(pwm_pin, 1'b0, "R5 halted");
        write(2'd2, 8'b011);
        check(pwm_pin, 1'b1, "R5 restart at 0");
        @(negedge clk);
        check(pwm_pin, 1'b0, "R5 restart idx1");
        @(negedge clk); @(negedge clk);
        check(pwm_pin, 1'b1, "R5 restart idx3");
    endtask

    task automatic t_select();
        write(2'd2, 8'b001);
        for (int i = 0; i < 3; i++) begin
            check(pwm_pin, 1'b0, "R10 pin gated");
            check(pwm_oe, 1'b0, "R10 oe off");
            @(negedge clk);
        end
        write(2'd2, 8'b011);
        check(pwm_oe, 1'b1, "R1 control reload");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run_and_double_buffer();
        t_stopped_loads();
        t_select();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule